// File: doc/BRIEF.md
# Banked Program Status Register File

This block keeps a processor's current status word and a saved status copy for each of the five privileged modes. The status word carries the four condition flags N, Z, C and V in bits 31:28, the two interrupt mask bits at 7 (I) and 6 (F), and a five-bit mode field in bits 4:0. The mode field decides which saved copy a saved-status access reaches. Software has no way to name another mode's copy directly. To switch copies, it changes mode by reading the word, replacing bits 4:0 and writing the whole word back.

Three ports reach the registers. A write port serves move-to-status operations. It carries a target select (current or saved), a field select (whole word or flags only) and 32 data bits. A combinational read port serves move-from-status operations. A flag-update input lets the ALU load new condition flags when the executing instruction asks for flags to be set.

Every access is checked against the privilege of the current mode, and an illegal access raises `access_err` in the same cycle. The write port has no back-pressure: a request with `wr_valid` high is always taken in that cycle. The read port answers within the same cycle, so neither port needs a ready signal.

Top module: `psr_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the current word becomes 0x000000D3 (mode 10011, I and F set, flags clear) and every saved copy becomes zero.
- R2: A flags-only write to the current word (`wr_target`=0, `wr_flags_only`=1) loads bits 31:28 from the data and keeps bits 27:0 in every mode. For example, data 0x10000000 sets V and clears N, Z and C.
- R3: A whole-word write to the current word in a privileged mode replaces all 32 bits. The new mode field selects the saved copy from the next cycle on.
- R4: In mode 10000 or 00000, a whole-word write to the current word changes only bits 31:28. It raises no error.
- R5: Saved accesses (`wr_target`/`rd_target`=1) reach the copy of the current mode. The copies are SVC (10011 or 00011), IRQ (10010 or 00010), FIQ (10001 or 00001), Abort (10111) and Undefined (11011). Each 26-bit mode shares its 32-bit counterpart's copy.
- R6: A saved-status read or write in mode 10000 or 00000 raises `access_err`. A read returns zero and a write changes nothing.
- R7: The legal mode values are the ten listed in R4 and R5. A whole-word write from a privileged mode, to either target, whose bits 4:0 hold any other value raises `access_err` and leaves the register unchanged.
- R8: With `flag_set` high, `flag_nzcv` (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V) is loaded into bits 31:28 of the current word. With `flag_set` low and no write, the current word holds.
- R9: When a write request to the current word and `flag_set` arrive in the same cycle, the write decides the result and `flag_nzcv` is dropped. This holds even if the write is rejected.
- R10: `rd_data` is combinational. It returns the current word when `rd_target`=0 and the selected saved copy when `rd_target`=1. `access_err` is also combinational and reflects the requests present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request, accepted in the same cycle |
| wr_target | input | 1 | 0 = current word, 1 = saved copy of the current mode |
| wr_flags_only | input | 1 | 1 = write bits 31:28 only, 0 = whole word |
| wr_data | input | 32 | Write data |
| rd_req | input | 1 | Read request (used for error checking) |
| rd_target | input | 1 | 0 = current word, 1 = saved copy of the current mode |
| rd_data | output | 32 | Read data, combinational |
| flag_set | input | 1 | ALU set-flags qualifier |
| flag_nzcv | input | 4 | New N, Z, C, V flags from the ALU |
| cur_status | output | 32 | Current status word |
| access_err | output | 1 | Illegal access in this cycle |

## Verification
The assertions check on every cycle the properties of the current word. Flags-only writes must keep the control bits. User-mode writes must not reach the control bits. The word must hold when nothing drives it, and the ALU flags must load when no write competes. The mode field must always hold a legal value. A user-mode saved read must return zero together with an error. Which saved copy answers in each mode, the sharing of copies between 26-bit and 32-bit modes, and the order of read-modify-write mode changes can only be shown by the bench's scenarios. The bench compares every cycle against its own reference model.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W      = 32;
  localparam int FLAG_HI    = 31;
  localparam int FLAG_LO    = 28;
  localparam int FLAG_W     = FLAG_HI - FLAG_LO + 1;
  localparam int MODE_W     = 5;
  localparam int NUM_BANKS  = 5;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  typedef enum logic [MODE_W-1:0] {
    M_USR26 = 5'b00000, M_FIQ26 = 5'b00001, M_IRQ26 = 5'b00010, M_SVC26 = 5'b00011,
    M_USR   = 5'b10000, M_FIQ   = 5'b10001, M_IRQ   = 5'b10010, M_SVC   = 5'b10011,
    M_ABT   = 5'b10111, M_UND   = 5'b11011
  } mode_e;

  localparam logic [BANK_IDX_W-1:0] BK_SVC = 3'd0;
  localparam logic [BANK_IDX_W-1:0] BK_IRQ = 3'd1;
  localparam logic [BANK_IDX_W-1:0] BK_ABT = 3'd2;
  localparam logic [BANK_IDX_W-1:0] BK_UND = 3'd3;
  localparam logic [BANK_IDX_W-1:0] BK_FIQ = 3'd4;

  function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USR26, M_FIQ26, M_IRQ26, M_SVC26,
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0]     mode,
  output logic                  legal,
  output logic                  priv,
  output logic [BANK_IDX_W-1:0] bank
);
  always_comb begin
    legal = mode_is_legal(mode);
    priv  = 1'b1;
    bank  = BK_SVC;
    case (mode)
      M_USR26, M_USR: priv = 1'b0;
      M_FIQ26, M_FIQ: bank = BK_FIQ;
      M_IRQ26, M_IRQ: bank = BK_IRQ;
      M_SVC26, M_SVC: bank = BK_SVC;
      M_ABT:          bank = BK_ABT;
      M_UND:          bank = BK_UND;
      default:        priv = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int W  = PSR_W,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_flags_only,
  input  logic [IW-1:0] sel,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] bank_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (wr_en && sel == IW'(g)) begin
        if (wr_flags_only) bank_q[g][FLAG_HI:FLAG_LO] <= wr_data[FLAG_HI:FLAG_LO];
        else               bank_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel == IW'(i)) rd_data = bank_q[i];
    end
  end
endmodule

// File: rtl/psr_current_reg.sv
module psr_current_reg
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_flags_only,
  input  logic [PSR_W-1:0]  wr_data,
  input  logic              priv,
  input  logic              flag_set,
  input  logic [FLAG_W-1:0] flag_nzcv,
  output logic [PSR_W-1:0]  cur_q,
  output logic              wr_reject
);
  logic flags_path;

  assign flags_path = wr_flags_only || !priv;
  assign wr_reject  = wr_en && !flags_path && !mode_is_legal(wr_data[MODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= PSR_RESET;
    end else if (wr_en) begin
      if (flags_path)      cur_q[FLAG_HI:FLAG_LO] <= wr_data[FLAG_HI:FLAG_LO];
      else if (!wr_reject) cur_q <= wr_data;
    end else if (flag_set) begin
      cur_q[FLAG_HI:FLAG_LO] <= flag_nzcv;
    end
  end

  // R2
  flagsonly_keep_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_flags_only |=> cur_q[FLAG_LO-1:0] == $past(cur_q[FLAG_LO-1:0])
                               && cur_q[FLAG_HI:FLAG_LO] == $past(wr_data[FLAG_HI:FLAG_LO]));

  // R4
  user_ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !priv |=> cur_q[FLAG_LO-1:0] == $past(cur_q[FLAG_LO-1:0]));

  // R7
  reject_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(cur_q));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !flag_set |=> $stable(cur_q));

  // R8
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && flag_set |=> cur_q[FLAG_HI:FLAG_LO] == $past(flag_nzcv)
                           && cur_q[FLAG_LO-1:0] == $past(cur_q[FLAG_LO-1:0]));
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic        wr_target,
  input  logic        wr_flags_only,
  input  logic [31:0] wr_data,
  input  logic        rd_req,
  input  logic        rd_target,
  output logic [31:0] rd_data,
  input  logic        flag_set,
  input  logic [3:0]  flag_nzcv,
  output logic [31:0] cur_status,
  output logic        access_err
);
  logic [PSR_W-1:0]      cur_q, sav_rd;
  logic                  cur_legal, cur_priv, cur_reject;
  logic [BANK_IDX_W-1:0] cur_bank;
  logic                  cur_wr, sav_req, sav_ok, sav_err, rd_err;

  psr_mode_decode u_dec (
    .mode  (cur_q[MODE_W-1:0]),
    .legal (cur_legal),
    .priv  (cur_priv),
    .bank  (cur_bank)
  );

  assign cur_wr = wr_valid && !wr_target;

  psr_current_reg u_cur (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (cur_wr),
    .wr_flags_only (wr_flags_only),
    .wr_data       (wr_data),
    .priv          (cur_priv),
    .flag_set      (flag_set),
    .flag_nzcv     (flag_nzcv),
    .cur_q         (cur_q),
    .wr_reject     (cur_reject)
  );

  assign sav_req = wr_valid && wr_target;
  assign sav_ok  = cur_priv && (wr_flags_only || mode_is_legal(wr_data[MODE_W-1:0]));
  assign sav_err = sav_req && !sav_ok;
  assign rd_err  = rd_req && rd_target && !cur_priv;

  psr_saved_bank #(.NB(NUM_BANKS), .W(PSR_W)) u_sav (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (sav_req && sav_ok),
    .wr_flags_only (wr_flags_only),
    .sel           (cur_bank),
    .wr_data       (wr_data),
    .rd_data       (sav_rd)
  );

  assign rd_data    = !rd_target ? cur_q : (cur_priv ? sav_rd : '0);
  assign cur_status = cur_q;
  assign access_err = cur_reject || sav_err || rd_err;

  // R6
  user_saved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_target && !cur_priv |-> rd_data == '0 && access_err);

  // R7
  mode_always_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_legal);

  // R9
  write_beats_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr && wr_flags_only && flag_set |=> cur_status[31:28] == $past(wr_data[31:28]));
endmodule

// File: tb/psr_bank_tb_top.sv
`timescale 1ns/1ps
module psr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 0, wr_target = 0, wr_flags_only = 0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 0, rd_target = 0;
  logic [31:0] rd_data;
  logic        flag_set = 0;
  logic [3:0]  flag_nzcv = '0;
  logic [31:0] cur_status;
  logic        access_err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_cur;
  logic [31:0] m_sav [5];

  always #2.5 clk = ~clk;

  psr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_target(wr_target),
    .wr_flags_only(wr_flags_only), .wr_data(wr_data), .rd_req(rd_req),
    .rd_target(rd_target), .rd_data(rd_data), .flag_set(flag_set),
    .flag_nzcv(flag_nzcv), .cur_status(cur_status), .access_err(access_err)
  );

  function automatic int m_bank(input logic [4:0] m);
    case (m[3:0])
      4'b0011: return 0;
      4'b0010: return 1;
      4'b0111: return 2;
      4'b1011: return 3;
      4'b0001: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_legal(input logic [4:0] m);
    return m inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
  endfunction

  function automatic bit m_priv(input logic [4:0] m);
    return !(m == 5'h00 || m == 5'h10);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    logic [31:0] e_rd;
    bit          e_err, pv, lg;
    #1;
    pv = m_priv(m_cur[4:0]);
    lg = m_legal(wr_data[4:0]);
    e_rd  = !rd_target ? m_cur : (pv ? m_sav[m_bank(m_cur[4:0])] : 32'h0);
    e_err = (rd_req && rd_target && !pv)
          || (wr_valid && wr_target && (!pv || (!wr_flags_only && !lg)))
          || (wr_valid && !wr_target && !wr_flags_only && pv && !lg);
    if (rst_n) begin
      chk({tag, " R10 rd_data"}, rd_data, e_rd);
      chk({tag, " R10 access_err"}, {31'b0, access_err}, {31'b0, e_err});
      chk({tag, " cur_status"}, cur_status, m_cur);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_cur = 32'h0000_00D3;
      foreach (m_sav[i]) m_sav[i] = '0;
    end else begin
      if (wr_valid && !wr_target) begin
        if (wr_flags_only || !pv) m_cur[31:28] = wr_data[31:28];
        else if (lg)              m_cur = wr_data;
      end else if (flag_set) begin
        m_cur[31:28] = flag_nzcv;
      end
      if (wr_valid && wr_target && pv) begin
        if (wr_flags_only) m_sav[m_bank(m_cur[4:0])][31:28] = wr_data[31:28];
        else if (lg)       m_sav[m_bank(m_cur[4:0])] = wr_data;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = 0; wr_target = 0; wr_flags_only = 0; wr_data = '0;
    rd_req = 0; rd_target = 0; flag_set = 0; flag_nzcv = '0;
  endtask

  task automatic wr(input bit tgt, input bit fo, input logic [31:0] d, input string tag);
    idle(); wr_valid = 1; wr_target = tgt; wr_flags_only = fo; wr_data = d;
    cycle(tag);
  endtask

  task automatic rd(input bit tgt, input string tag);
    idle(); rd_req = 1; rd_target = tgt;
    cycle(tag);
  endtask

  task automatic set_mode(input logic [4:0] m, input string tag);
    wr(0, 0, (cur_status & ~32'h1F) | {27'b0, m}, tag);
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    cycle("R1 reset"); cycle("R1 reset");
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset value and zeroed saved copy
    rd(1, "R1 saved zero");
    chk("R1 reset word", cur_status, 32'h0000_00D3);
    // R2: flags-only write, V only
    wr(0, 1, 32'h1000_0000, "R2 flags-only");
    chk("R2 V set", cur_status, 32'h1000_00D3);
    // R8: ALU flags loaded, then held
    idle(); flag_set = 1; flag_nzcv = 4'b1010; cycle("R8 load");
    chk("R8 flags", cur_status, 32'hA000_00D3);
    idle(); flag_nzcv = 4'b0101; cycle("R8 hold");
    chk("R8 hold", cur_status, 32'hA000_00D3);
    // R9: write and flag update together, write wins
    idle(); wr_valid = 1; wr_flags_only = 1; wr_data = 32'h3000_0000;
    flag_set = 1; flag_nzcv = 4'b1100; cycle("R9 collide");
    chk("R9 write wins", cur_status, 32'h3000_00D3);
    idle(); wr_valid = 1; wr_data = 32'h0000_00D5; flag_set = 1; flag_nzcv = 4'b1111;
    cycle("R9 rejected write");
    chk("R9 rejected keeps", cur_status, 32'h3000_00D3);
    // R5: bank per mode
    wr(1, 0, 32'h6000_00D2, "R5 svc saved");
    set_mode(5'h12, "R3 to IRQ");
    chk("R3 mode IRQ", cur_status, 32'h3000_00D2);
    rd(1, "R5 irq empty");
    wr(1, 0, 32'hA000_0010, "R5 irq saved");
    set_mode(5'h17, "R3 to ABT");  wr(1, 0, 32'h1111_1117, "R5 abt saved");
    set_mode(5'h1B, "R3 to UND");  wr(1, 0, 32'h2222_221B, "R5 und saved");
    set_mode(5'h11, "R3 to FIQ");  wr(1, 0, 32'h4444_4411, "R5 fiq saved");
    wr(1, 1, 32'hF000_0000, "R5 saved flags-only");
    idle(); rd_req = 1; rd_target = 1; #1;
    chk("R5 fiq copy", rd_data, 32'hF444_4411);
    cycle("R5 fiq read");
    set_mode(5'h02, "R5 to IRQ26"); rd(1, "R5 irq26 shares");
    set_mode(5'h13, "R3 to SVC");   rd(1, "R5 svc kept");
    set_mode(5'h17, "R5 back ABT"); rd(1, "R5 abt kept");
    // R7: illegal mode values, both targets
    wr(0, 0, 32'h0000_00D5, "R7 cur illegal");
    wr(1, 0, 32'h0000_001F, "R7 sav illegal");
    rd(1, "R7 sav unchanged");
    // R4 and R6: user mode
    set_mode(5'h10, "R3 to USR");
    wr(0, 0, 32'hF000_00D3, "R4 user whole");
    chk("R4 only flags", cur_status[27:0], 28'h0000010 | (cur_status[27:0] & 28'hFFFFFE0));
    rd(1, "R6 user saved read");
    wr(1, 0, 32'h1234_5613, "R6 user saved write");
    do_reset();
    set_mode(5'h00, "R6 to USR26");
    rd(1, "R6 usr26 saved read");
    wr(0, 0, 32'h5000_0013, "R4 usr26 whole");
    do_reset();
    rd(1, "R6 saved untouched");
    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [4:0] modes [12];
      modes = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h15, 5'h1F};
      if (i % 60 == 59) begin do_reset(); continue; end
      idle();
      wr_valid = ($urandom % 2) == 0;
      wr_target = $urandom % 2;
      wr_flags_only = ($urandom % 3) == 0;
      wr_data = {$urandom} & 32'hFFFF_FFE0 | {27'b0, modes[$urandom % 12]};
      rd_req = $urandom % 2;
      rd_target = $urandom % 2;
      flag_set = $urandom % 2;
      flag_nzcv = 4'($urandom);
      cycle("R3 R5 R8 mixed");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule